// File: doc/BRIEF.md
# Program-Counter Gated Memory Access Checker

This block guards one protected software module inside a small processor. It keeps the module's layout: the address range of its code region, the address range of its private data region, and a flag that says whether protection is active. Every cycle it compares three addresses against that layout: the program counter of the instruction now executing, the program counter of the instruction before it, and the address on the data bus. If a rule is broken, it raises a violation flag in the same cycle.

The rights of an access depend on where the program counter is. Private data may be touched only by code that runs from the module's own code region. Code arriving from outside may enter the code region only at its first address, which is the single entry point. A protect operation loads the four bounds and turns protection on. An unprotect operation turns protection off, and while protection is off every check is silent.

The violation output is purely combinational, so the check adds no cycle to the access path. The surrounding core decides what to do with a violation.

Top module: `pcmac_top`

## Requirements
- R1: While rst_ni is low, and after it is released, violation_o is 0 until a load, whatever the address inputs are. Reset clears the enable flag.
- R2: While protection is off, violation_o stays 0 for every combination of pc_i, pc_prev_i, mem_addr_i and mem_en_i.
- R3: With protection on, mem_en_i high, mem_addr_i inside the data range and pc_i outside the code range, violation_o is 1.
- R4: With protection on, an access to the data range while pc_i is inside the code range (and the entry rule is met) gives violation_o = 0.
- R5: When mem_en_i is 0, mem_addr_i has no effect on violation_o.
- R6: A step from a pc_prev_i outside the code range to pc_i equal to the code start address is allowed (violation_o = 0), also when it comes with a data access.
- R7: With protection on, pc_i inside the code range, pc_prev_i outside it and pc_i not equal to the code start gives violation_o = 1.
- R8: With pc_prev_i and pc_i both inside the code range, no entry violation is raised.
- R9: Each range includes its start and excludes its end: an address equal to a start is inside, and an address equal to an end is outside. This holds for pc_i, pc_prev_i and mem_addr_i.
- R10: A pulse on load_i stores txt_lo_i, txt_hi_i, dat_lo_i and dat_hi_i and sets the enable flag at the next rising edge of clk_i, replacing any earlier layout. violation_o follows the inputs in the same cycle, with no register in between.
- R11: A pulse on clear_i alone drops the enable flag at the next rising edge.
- R12: When load_i and clear_i are high in the same cycle, the load wins and protection is on after the edge.
- R13: A data-bus access to the code range from outside code is not flagged. Write protection of the code region lies elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Protect: store the layout and turn protection on |
| clear_i | input | 1 | Unprotect: turn protection off |
| txt_lo_i | input | AW | Code region start (inclusive, entry point) |
| txt_hi_i | input | AW | Code region end (exclusive) |
| dat_lo_i | input | AW | Data region start (inclusive) |
| dat_hi_i | input | AW | Data region end (exclusive) |
| pc_i | input | AW | Program counter of the current instruction |
| pc_prev_i | input | AW | Program counter of the previous instruction |
| mem_addr_i | input | AW | Data bus address |
| mem_en_i | input | 1 | Data bus access strobe |
| violation_o | output | 1 | Access rule broken this cycle |

## Verification
Protect and unprotect can arrive in the same cycle, and so can a data-bus access and an entry into the code region. The bench raises load_i and clear_i together and then presents an outside data access: a 1 on violation_o shows that the load won. It also enters at the code start while it accesses private data, and leaves at an address just past the start with the same access. This tests that the two rules are judged on their own and that an allowed entry gives the data right at once.

// File: rtl/pcmac_pkg.sv
package pcmac_pkg;

  // comparator slots, one per address that is matched against a range
  typedef enum int unsigned {
    CMP_PC_TXT   = 0,
    CMP_PREV_TXT = 1,
    CMP_ADDR_DAT = 2
  } cmp_slot_e;

  localparam int unsigned N_CMP = 3;

  typedef struct packed {
    logic dat_breach;
    logic entry_breach;
  } rule_hits_t;

endpackage

// File: rtl/pcmac_range_cmp.sv
module pcmac_range_cmp #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  output logic          hit_o
);
  // start inclusive, end exclusive
  always_comb hit_o = (addr_i >= lo_i) && (addr_i < hi_i);
endmodule

// File: rtl/pcmac_layout_regs.sv
module pcmac_layout_regs #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          clear_i,
  input  logic [AW-1:0] txt_lo_i,
  input  logic [AW-1:0] txt_hi_i,
  input  logic [AW-1:0] dat_lo_i,
  input  logic [AW-1:0] dat_hi_i,
  output logic [AW-1:0] txt_lo_o,
  output logic [AW-1:0] txt_hi_o,
  output logic [AW-1:0] dat_lo_o,
  output logic [AW-1:0] dat_hi_o,
  output logic          en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txt_lo_o <= '0;
      txt_hi_o <= '0;
      dat_lo_o <= '0;
      dat_hi_o <= '0;
      en_o     <= 1'b0;
    end else if (load_i) begin
      // load takes priority over a coincident clear
      txt_lo_o <= txt_lo_i;
      txt_hi_o <= txt_hi_i;
      dat_lo_o <= dat_lo_i;
      dat_hi_o <= dat_hi_i;
      en_o     <= 1'b1;
    end else if (clear_i) begin
      en_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/pcmac_rule_eval.sv
module pcmac_rule_eval
  import pcmac_pkg::*;
(
  input  logic       en_i,
  input  logic       pc_in_txt_i,
  input  logic       prev_in_txt_i,
  input  logic       pc_at_entry_i,
  input  logic       addr_in_dat_i,
  input  logic       mem_en_i,
  output rule_hits_t hits_o,
  output logic       violation_o
);
  always_comb begin
    hits_o.dat_breach   = mem_en_i && addr_in_dat_i && !pc_in_txt_i;
    hits_o.entry_breach = pc_in_txt_i && !prev_in_txt_i && !pc_at_entry_i;
    violation_o         = en_i && (hits_o.dat_breach || hits_o.entry_breach);
  end
endmodule

// File: rtl/pcmac_top.sv
module pcmac_top
  import pcmac_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          clear_i,
  input  logic [AW-1:0] txt_lo_i,
  input  logic [AW-1:0] txt_hi_i,
  input  logic [AW-1:0] dat_lo_i,
  input  logic [AW-1:0] dat_hi_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] pc_prev_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic          mem_en_i,
  output logic          violation_o
);
  logic [AW-1:0] txt_lo_q, txt_hi_q, dat_lo_q, dat_hi_q;
  logic          en_q;

  pcmac_layout_regs #(.AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .clear_i  (clear_i),
    .txt_lo_i (txt_lo_i),
    .txt_hi_i (txt_hi_i),
    .dat_lo_i (dat_lo_i),
    .dat_hi_i (dat_hi_i),
    .txt_lo_o (txt_lo_q),
    .txt_hi_o (txt_hi_q),
    .dat_lo_o (dat_lo_q),
    .dat_hi_o (dat_hi_q),
    .en_o     (en_q)
  );

  logic [AW-1:0] cmp_addr [N_CMP];
  logic [AW-1:0] cmp_lo   [N_CMP];
  logic [AW-1:0] cmp_hi   [N_CMP];
  logic [N_CMP-1:0] cmp_hit;

  always_comb begin
    cmp_addr[CMP_PC_TXT]   = pc_i;
    cmp_lo[CMP_PC_TXT]     = txt_lo_q;
    cmp_hi[CMP_PC_TXT]     = txt_hi_q;
    cmp_addr[CMP_PREV_TXT] = pc_prev_i;
    cmp_lo[CMP_PREV_TXT]   = txt_lo_q;
    cmp_hi[CMP_PREV_TXT]   = txt_hi_q;
    cmp_addr[CMP_ADDR_DAT] = mem_addr_i;
    cmp_lo[CMP_ADDR_DAT]   = dat_lo_q;
    cmp_hi[CMP_ADDR_DAT]   = dat_hi_q;
  end

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    pcmac_range_cmp #(.AW(AW)) u_cmp (
      .addr_i (cmp_addr[g]),
      .lo_i   (cmp_lo[g]),
      .hi_i   (cmp_hi[g]),
      .hit_o  (cmp_hit[g])
    );
  end

  logic       pc_at_entry;
  rule_hits_t hits;

  always_comb pc_at_entry = (pc_i == txt_lo_q);

  pcmac_rule_eval u_eval (
    .en_i          (en_q),
    .pc_in_txt_i   (cmp_hit[CMP_PC_TXT]),
    .prev_in_txt_i (cmp_hit[CMP_PREV_TXT]),
    .pc_at_entry_i (pc_at_entry),
    .addr_in_dat_i (cmp_hit[CMP_ADDR_DAT]),
    .mem_en_i      (mem_en_i),
    .hits_o        (hits),
    .violation_o   (violation_o)
  );
endmodule

// File: rtl/pcmac_chk.sv
module pcmac_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic          clear_i,
  input logic          en_q,
  input logic [AW-1:0] txt_lo_q,
  input logic [AW-1:0] txt_hi_q,
  input logic [AW-1:0] dat_lo_q,
  input logic [AW-1:0] dat_hi_q,
  input logic [AW-1:0] pc_i,
  input logic [AW-1:0] pc_prev_i,
  input logic [AW-1:0] mem_addr_i,
  input logic          mem_en_i,
  input logic          violation_o
);
  logic pc_in, prev_in, addr_in;
  always_comb begin
    pc_in   = (pc_i >= txt_lo_q) && (pc_i < txt_hi_q);
    prev_in = (pc_prev_i >= txt_lo_q) && (pc_prev_i < txt_hi_q);
    addr_in = (mem_addr_i >= dat_lo_q) && (mem_addr_i < dat_hi_q);
  end

  assert_quiet_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !violation_o);

  assert_outside_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && mem_en_i && addr_in && !pc_in |-> violation_o);

  assert_bad_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && pc_in && !prev_in && (pc_i != txt_lo_q) |-> violation_o);

  assert_inside_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_in && prev_in |-> !violation_o);

  assert_load_enables_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> en_q);

  assert_clear_drops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !load_i |=> !en_q);

  assert_load_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && clear_i |=> en_q);
endmodule

bind pcmac_top pcmac_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .clear_i     (clear_i),
  .en_q        (en_q),
  .txt_lo_q    (txt_lo_q),
  .txt_hi_q    (txt_hi_q),
  .dat_lo_q    (dat_lo_q),
  .dat_hi_q    (dat_hi_q),
  .pc_i        (pc_i),
  .pc_prev_i   (pc_prev_i),
  .mem_addr_i  (mem_addr_i),
  .mem_en_i    (mem_en_i),
  .violation_o (violation_o)
);

// File: tb/tb_pcmac_top.sv
module tb_pcmac_top;
  localparam int unsigned AW = 16;

  typedef struct packed {
    logic [AW-1:0] pc;
    logic [AW-1:0] prev;
    logic [AW-1:0] addr;
    logic          men;
    logic          exp;
    logic [7:0]    req;
  } vec_t;

  // layout: code [0x1000,0x1100), data [0x2000,0x2080)
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{pc:16'h0500, prev:16'h04fe, addr:16'h2010, men:1'b1, exp:1'b1, req:8'd3},  // R3
    '{pc:16'h1010, prev:16'h100e, addr:16'h2010, men:1'b1, exp:1'b0, req:8'd4},  // R4
    '{pc:16'h0500, prev:16'h04fe, addr:16'h2010, men:1'b0, exp:1'b0, req:8'd5},  // R5
    '{pc:16'h1000, prev:16'h0600, addr:16'h0000, men:1'b0, exp:1'b0, req:8'd6},  // R6
    '{pc:16'h1002, prev:16'h0600, addr:16'h0000, men:1'b0, exp:1'b1, req:8'd7},  // R7
    '{pc:16'h1050, prev:16'h104e, addr:16'h0000, men:1'b0, exp:1'b0, req:8'd8},  // R8
    '{pc:16'h10fe, prev:16'h0700, addr:16'h0000, men:1'b0, exp:1'b1, req:8'd7},  // R7 last word
    '{pc:16'h1100, prev:16'h0700, addr:16'h0000, men:1'b0, exp:1'b0, req:8'd9},  // R9 code end
    '{pc:16'h0500, prev:16'h04fe, addr:16'h2000, men:1'b1, exp:1'b1, req:8'd9},  // R9 data start
    '{pc:16'h0500, prev:16'h04fe, addr:16'h2080, men:1'b1, exp:1'b0, req:8'd9},  // R9 data end
    '{pc:16'h0500, prev:16'h04fe, addr:16'h1ffe, men:1'b1, exp:1'b0, req:8'd9},  // R9 below data
    '{pc:16'h1004, prev:16'h1100, addr:16'h0000, men:1'b0, exp:1'b1, req:8'd9},  // R9 prev at end
    '{pc:16'h0500, prev:16'h04fe, addr:16'h1010, men:1'b1, exp:1'b0, req:8'd13}, // R13
    '{pc:16'h1000, prev:16'h0600, addr:16'h2000, men:1'b1, exp:1'b0, req:8'd6},  // R6 with data
    '{pc:16'h10fe, prev:16'h10fc, addr:16'h207e, men:1'b1, exp:1'b0, req:8'd4}   // R4 edges
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0, clear_i = 1'b0;
  logic [AW-1:0] txt_lo_i = '0, txt_hi_i = '0, dat_lo_i = '0, dat_hi_i = '0;
  logic [AW-1:0] pc_i = '0, pc_prev_i = '0, mem_addr_i = '0;
  logic          mem_en_i = 1'b0;
  logic          violation_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pcmac_top #(.AW(AW)) dut (.*);

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: violation_o=%b expected %b", req, got, exp);
    end
  endtask

  task automatic drive(input logic [AW-1:0] pc, prev, addr, input logic men);
    pc_i = pc; pc_prev_i = prev; mem_addr_i = addr; mem_en_i = men;
  endtask

  task automatic set_layout(input logic [AW-1:0] tl, th, dl, dh);
    txt_lo_i = tl; txt_hi_i = th; dat_lo_i = dl; dat_hi_i = dh;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    set_layout(16'h1000, 16'h1100, 16'h2000, 16'h2080);
    drive(16'h0500, 16'h04fe, 16'h2010, 1'b1);
    load_i = 1'b1;
    repeat (2) @(negedge clk_i);
    #1 check(violation_o, 1'b0, "R1 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1; load_i = 1'b0;
    @(negedge clk_i);
    #1 check(violation_o, 1'b0, "R1 after reset");
    drive(16'h1002, 16'h0600, 16'h2000, 1'b1);
    #1 check(violation_o, 1'b0, "R2 off, bad entry");

    // R10: load lands on the edge, not before
    @(negedge clk_i);
    drive(16'h0500, 16'h04fe, 16'h2010, 1'b1);
    load_i = 1'b1;
    #1 check(violation_o, 1'b0, "R10 before edge");
    @(negedge clk_i);
    load_i = 1'b0;
    #1 check(violation_o, 1'b1, "R10 after edge");

    foreach (VEC[i]) begin
      @(negedge clk_i);
      drive(VEC[i].pc, VEC[i].prev, VEC[i].addr, VEC[i].men);
      #2 check(violation_o, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
    end

    // R5: address sweeps with strobe low leave output unchanged
    @(negedge clk_i);
    drive(16'h0500, 16'h04fe, 16'h2000, 1'b0);
    #1 check(violation_o, 1'b0, "R5 strobe low data start");
    mem_addr_i = 16'h207f;
    #1 check(violation_o, 1'b0, "R5 strobe low data end-1");

    // R11: clear alone turns checks off
    @(negedge clk_i);
    drive(16'h0500, 16'h04fe, 16'h2010, 1'b1);
    clear_i = 1'b1;
    #1 check(violation_o, 1'b1, "R11 before edge");
    @(negedge clk_i);
    clear_i = 1'b0;
    #1 check(violation_o, 1'b0, "R11 after clear");
    drive(16'h1002, 16'h0600, 16'h0000, 1'b0);
    #1 check(violation_o, 1'b0, "R2 after clear, bad entry");

    // R12: load and clear together, load wins
    @(negedge clk_i);
    drive(16'h0500, 16'h04fe, 16'h2010, 1'b1);
    load_i = 1'b1; clear_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0; clear_i = 1'b0;
    #1 check(violation_o, 1'b1, "R12 load beats clear");

    // R10: new layout replaces the old one
    @(negedge clk_i);
    set_layout(16'h3000, 16'h3040, 16'h4000, 16'h4010);
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    #1 check(violation_o, 1'b0, "R10 old data range released");
    mem_addr_i = 16'h4000;
    #1 check(violation_o, 1'b1, "R10 new data range guarded");
    drive(16'h1002, 16'h0600, 16'h0000, 1'b0);
    #1 check(violation_o, 1'b0, "R10 old code range released");
    drive(16'h3002, 16'h0600, 16'h0000, 1'b0);
    #1 check(violation_o, 1'b1, "R7 new code range entry");
    drive(16'h3000, 16'h0600, 16'h400f, 1'b1);
    #1 check(violation_o, 1'b0, "R6 entry with data access");
    drive(16'h3002, 16'h0600, 16'h400f, 1'b1);
    #1 check(violation_o, 1'b1, "R7 entry off start with data access");

    @(negedge clk_i);
    finish_run();
  end
endmodule